// File: doc/BRIEF.md
# Packet Page Allocator

This block manages a NIC packet buffer that is split into fixed 2 KB pages. A bit per page records whether that page is in use. A host writes a command byte to drive the allocator. The top three bits of the byte select the operation, and the lower five bits are don't-care. The operations are:

- claim a page for transmit
- wipe all allocation state
- drop or drop-and-free the oldest receive entry
- free the page named by the packet-number input
- queue that page for transmit
- empty the transmit queue

The receive path asks for pages on a separate request port. Each granted page is recorded in a receive queue.

A transmit claim can find every page taken. In that case the result register reads 0x80 and the claim stays pending. The next page release serves the pending claim automatically, and the freed page goes straight back to the transmit side. The block reports the last claim result, a sticky allocation flag and a one-cycle allocation-done pulse. It also reports the free-page count and the heads and depths of both queues.

Top module: `ppa_mmu`

## Requirements
- R1: After reset the page map is all clear and the free count equals the page count. The result register reads 0x80 and the allocation flag is low. Both queues are empty, and an empty queue head reads 0x80.
- R2: Command code 1 (byte bits [7:5] = 3'd1) claims the lowest-numbered free page. On the next cycle the result register holds that page number, its map bit is set, the allocation flag is high and the allocation-done output pulses high for that one cycle.
- R3: Code 1 first clears the allocation flag. If no page is free, the result register reads 0x80, the flag stays low and the claim becomes pending.
- R4: While a claim is pending, any page release immediately re-claims the lowest free page after the release. The result register takes that page number, the flag rises and the map bit stays set.
- R5: Code 5 clears the map bit of the page given on `pkt_num`.
- R6: Code 2 clears the whole page map and empties both queues.
- R7: A receive request with no command write in the same cycle is granted combinationally if a page is free and the receive queue is not full. The grant carries the lowest free page, marks it used and appends it to the receive queue. Otherwise no grant is given and nothing changes.
- R8: Code 3 removes the receive queue head without freeing its page. On an empty queue it does nothing.
- R9: Code 4 frees the page at the receive queue head and removes the entry. On an empty queue it does nothing.
- R10: Code 6 appends `pkt_num` to the transmit queue, whose head is visible on `tx_head`. The command is ignored when the queue already holds as many entries as there are pages.
- R11: Code 7 empties the transmit queue and leaves the page map untouched.
- R12: Code 0 changes nothing. Bits [4:0] of the command byte never affect which operation runs.
- R13: `free_pages` always equals the number of clear bits in the page map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Single-cycle command write strobe |
| cmd_byte | input | 8 | Command byte, operation in bits [7:5] |
| pkt_num | input | PW | Page operand for release and transmit enqueue |
| rx_req | input | 1 | Receive-side page request |
| rx_grant | output | 1 | Request granted this cycle |
| rx_page | output | PW | Page granted to the receive side |
| alloc_result | output | 8 | Last transmit claim result, 0x80 on failure |
| alloc_done | output | 1 | One-cycle pulse after a successful claim |
| alloc_flag | output | 1 | Sticky allocation flag |
| free_pages | output | CW | Number of free pages |
| page_map | output | N | Per-page in-use bits |
| rx_count | output | CW | Receive queue depth |
| rx_head | output | 8 | Oldest receive page, 0x80 if empty |
| tx_count | output | CW | Transmit queue depth |
| tx_head | output | 8 | Oldest transmit page, 0x80 if empty |

## Verification
The bench builds the block with four pages. At that size the buffer fills within four claims, so both the failed claim and the pending-retry path are reached within a handful of cycles. Four pages also let every page index appear in the 2-bit `pkt_num` operand. Finally, the transmit queue reaches its capacity after four enqueues, so an extra enqueue shows the ignore rule at the ports.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_TXALOC = 3'd1,
    OP_WIPE   = 3'd2,
    OP_RXDROP = 3'd3,
    OP_RXFREE = 3'd4,
    OP_FREE   = 3'd5,
    OP_TXPUSH = 3'd6,
    OP_TXCLR  = 3'd7
  } mmu_op_e;

  localparam int MAXP = 64;
  localparam logic [7:0] NO_PAGE = 8'h80;

  // Index of the lowest clear bit among the first n bits; n when all are set.
  function automatic int unsigned lowest_clear(logic [MAXP-1:0] m, int unsigned n);
    int unsigned r;
    r = n;
    for (int i = MAXP - 1; i >= 0; i--) begin
      if (i < int'(n) && !m[i]) r = i;
    end
    return r;
  endfunction

  // Number of clear bits among the first n bits.
  function automatic int unsigned clear_count(logic [MAXP-1:0] m, int unsigned n);
    int unsigned c;
    c = 0;
    for (int i = 0; i < MAXP; i++) begin
      if (i < int'(n) && !m[i]) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/ppa_scan.sv
module ppa_scan
  import ppa_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int CW = 3
) (
  input  logic [N-1:0]  mask,
  output logic          any_free,
  output logic [PW-1:0] first,
  output logic [CW-1:0] nfree
);
  logic [MAXP-1:0] wide;
  int unsigned     idx;

  always_comb begin
    wide = '0;
    wide[N-1:0] = mask;
    idx = lowest_clear(wide, N);
    any_free = (idx < N);
    first = any_free ? PW'(idx) : '0;
    nfree = CW'(clear_count(wide, N));
  end
endmodule

// File: rtl/ppa_queue.sv
module ppa_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  slot [DEPTH];
  logic          push_ok, pop_ok;
  logic [CW-1:0] wr_idx;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign wr_idx  = pop_ok ? count - 1'b1 : count;
  assign head    = slot[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else count <= count + CW'(push_ok) - CW'(pop_ok);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[i] <= '0;
      else if (push_ok && wr_idx == CW'(i)) slot[i] <= din;
      else if (pop_ok) begin
        if (i < DEPTH - 1) slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
      end
    end
  end
endmodule

// File: rtl/ppa_mmu.sv
module ppa_mmu
  import ppa_pkg::*;
#(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_byte,
  input  logic [PW-1:0] pkt_num,
  input  logic          rx_req,
  output logic          rx_grant,
  output logic [PW-1:0] rx_page,
  output logic [7:0]    alloc_result,
  output logic          alloc_done,
  output logic          alloc_flag,
  output logic [CW-1:0] free_pages,
  output logic [N-1:0]  page_map,
  output logic [CW-1:0] rx_count,
  output logic [7:0]    rx_head,
  output logic [CW-1:0] tx_count,
  output logic [7:0]    tx_head
);
  mmu_op_e       op;
  logic [N-1:0]  map_q, map_d, map_rel;
  logic [7:0]    res_q, res_d;
  logic          flag_q, flag_d, pend_q, pend_d, done_q, done_d;
  logic          any_free, rel_any;
  logic [PW-1:0] first_free, rel_first, rel_page, rx_hidx, tx_hidx;
  logic [CW-1:0] nfree, rel_nfree;
  logic          rx_empty, rx_full, tx_empty, tx_full;

  // Named events for the checker
  logic tx_claim_ev, rel_ev, retry_ev, wipe_ev;

  function automatic logic [N-1:0] page_bit(logic [PW-1:0] p);
    return {{(N-1){1'b0}}, 1'b1} << p;
  endfunction

  function automatic logic [7:0] as_byte(logic [PW-1:0] p);
    return {{(8-PW){1'b0}}, p};
  endfunction

  assign op          = mmu_op_e'(cmd_byte[7:5]);
  assign tx_claim_ev = cmd_we && op == OP_TXALOC;
  assign wipe_ev     = cmd_we && op == OP_WIPE;
  assign rel_ev      = cmd_we && (op == OP_FREE || (op == OP_RXFREE && !rx_empty));
  assign rel_page    = (op == OP_RXFREE) ? rx_hidx : pkt_num;
  assign map_rel     = map_q & ~page_bit(rel_page);
  assign retry_ev    = rel_ev && pend_q;
  assign rx_grant    = rx_req && !cmd_we && any_free && !rx_full;
  assign rx_page     = first_free;

  ppa_scan #(.N(N), .PW(PW), .CW(CW)) u_scan_cur (
    .mask(map_q), .any_free(any_free), .first(first_free), .nfree(nfree)
  );

  ppa_scan #(.N(N), .PW(PW), .CW(CW)) u_scan_rel (
    .mask(map_rel), .any_free(rel_any), .first(rel_first), .nfree(rel_nfree)
  );

  always_comb begin
    map_d  = map_q;
    res_d  = res_q;
    flag_d = flag_q;
    pend_d = pend_q;
    done_d = 1'b0;
    if (rx_grant) map_d = map_q | page_bit(first_free);
    if (tx_claim_ev) begin
      flag_d = 1'b0;
      if (any_free) begin
        map_d  = map_q | page_bit(first_free);
        res_d  = as_byte(first_free);
        flag_d = 1'b1;
        done_d = 1'b1;
        pend_d = 1'b0;
      end else begin
        res_d  = NO_PAGE;
        pend_d = 1'b1;
      end
    end
    if (rel_ev) begin
      map_d = map_rel;
      if (pend_q && rel_any) begin
        map_d  = map_rel | page_bit(rel_first);
        res_d  = as_byte(rel_first);
        flag_d = 1'b1;
        done_d = 1'b1;
        pend_d = 1'b0;
      end
    end
    if (wipe_ev) map_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q  <= '0;
      res_q  <= NO_PAGE;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      map_q  <= map_d;
      res_q  <= res_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  ppa_queue #(.DEPTH(N), .W(PW), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(wipe_ev), .push(rx_grant),
    .pop(cmd_we && (op == OP_RXDROP || op == OP_RXFREE)),
    .din(first_free), .head(rx_hidx), .count(rx_count),
    .empty(rx_empty), .full(rx_full)
  );

  ppa_queue #(.DEPTH(N), .W(PW), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(wipe_ev || (cmd_we && op == OP_TXCLR)),
    .push(cmd_we && op == OP_TXPUSH), .pop(1'b0),
    .din(pkt_num), .head(tx_hidx), .count(tx_count),
    .empty(tx_empty), .full(tx_full)
  );

  assign page_map     = map_q;
  assign free_pages   = nfree;
  assign alloc_result = res_q;
  assign alloc_flag   = flag_q;
  assign alloc_done   = done_q;
  assign rx_head      = rx_empty ? NO_PAGE : as_byte(rx_hidx);
  assign tx_head      = tx_empty ? NO_PAGE : as_byte(tx_hidx);
endmodule

// File: rtl/ppa_mmu_chk.sv
module ppa_mmu_chk #(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [7:0]    cmd_byte,
  input logic          rx_req,
  input logic          rx_grant,
  input logic [PW-1:0] rx_page,
  input logic [7:0]    alloc_result,
  input logic          alloc_done,
  input logic          alloc_flag,
  input logic [CW-1:0] free_pages,
  input logic [N-1:0]  page_map,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          retry_ev,
  input logic          tx_claim_ev
);
  AST_CLAIM_OK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_claim_ev && !(&page_map) |=> alloc_flag && alloc_done && alloc_result < 8'(N)); // R2

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> alloc_flag); // R2

  AST_CLAIM_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_claim_ev && (&page_map) |=> alloc_result == 8'h80 && !alloc_flag); // R3

  AST_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ev |=> alloc_result != 8'h80 && alloc_flag && alloc_done); // R4

  AST_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_byte[7:5] == 3'd2 |=> page_map == '0 && rx_count == '0 && tx_count == '0); // R6

  AST_RX_FREE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> !cmd_we && rx_req && page_map[rx_page] == 1'b0); // R7

  AST_TX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(N)); // R10

  AST_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_byte[7:5] == 3'd0 |=> $stable(page_map) && $stable(alloc_result)); // R12

  AST_FREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_pages) + $countones(page_map) == N); // R13
endmodule

bind ppa_mmu ppa_mmu_chk #(.N(N), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page),
  .alloc_result(alloc_result), .alloc_done(alloc_done), .alloc_flag(alloc_flag),
  .free_pages(free_pages), .page_map(page_map), .rx_count(rx_count),
  .tx_count(tx_count), .retry_ev(retry_ev), .tx_claim_ev(tx_claim_ev)
);

// File: tb/tb_ppa_mmu.sv
`timescale 1ns/100ps
module tb_ppa_mmu;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int CW = 3;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_we;
  logic [7:0]    cmd_byte;
  logic [PW-1:0] pkt_num;
  logic          rx_req;
  logic          rx_grant;
  logic [PW-1:0] rx_page;
  logic [7:0]    alloc_result, rx_head, tx_head;
  logic          alloc_done, alloc_flag;
  logic [CW-1:0] free_pages, rx_count, tx_count;
  logic [N-1:0]  page_map;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ppa_mmu #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .pkt_num(pkt_num), .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page),
    .alloc_result(alloc_result), .alloc_done(alloc_done), .alloc_flag(alloc_flag),
    .free_pages(free_pages), .page_map(page_map), .rx_count(rx_count),
    .rx_head(rx_head), .tx_count(tx_count), .tx_head(tx_head)
  );

  // Fields: we | cmd | pkt | rx_req | exp grant | exp map | exp result | exp flag | exp rx cnt | exp tx cnt
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 8'h20, 2'd0, 1'b0, 1'b0, 4'b0001, 8'h00, 1'b1, 3'd0, 3'd0}, // R2 first claim
    {1'b1, 8'h3F, 2'd0, 1'b0, 1'b0, 4'b0011, 8'h01, 1'b1, 3'd0, 3'd0}, // R12 low bits ignored, R2
    {1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 4'b0111, 8'h01, 1'b1, 3'd1, 3'd0}, // R7 grant page 2
    {1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 4'b1111, 8'h01, 1'b1, 3'd2, 3'd0}, // R7 grant page 3
    {1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 4'b1111, 8'h01, 1'b1, 3'd2, 3'd0}, // R7 full, refused
    {1'b1, 8'h20, 2'd0, 1'b0, 1'b0, 4'b1111, 8'h80, 1'b0, 3'd2, 3'd0}, // R3 failed claim
    {1'b1, 8'h00, 2'd0, 1'b1, 1'b0, 4'b1111, 8'h80, 1'b0, 3'd2, 3'd0}, // R12 no-op, R7 blocked
    {1'b1, 8'hA0, 2'd1, 1'b0, 1'b0, 4'b1111, 8'h01, 1'b1, 3'd2, 3'd0}, // R4 retry takes page 1
    {1'b1, 8'hA0, 2'd0, 1'b0, 1'b0, 4'b1110, 8'h01, 1'b1, 3'd2, 3'd0}, // R5 free page 0
    {1'b1, 8'h60, 2'd0, 1'b0, 1'b0, 4'b1110, 8'h01, 1'b1, 3'd1, 3'd0}, // R8 drop head, keep page
    {1'b1, 8'h80, 2'd0, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd0}, // R9 free head page 3
    {1'b1, 8'h80, 2'd0, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd0}, // R9 empty queue
    {1'b1, 8'hC0, 2'd1, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd1}, // R10
    {1'b1, 8'hC0, 2'd2, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd2}, // R10
    {1'b1, 8'hC0, 2'd3, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd3}, // R10
    {1'b1, 8'hC0, 2'd0, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd4}, // R10 full
    {1'b1, 8'hC0, 2'd3, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd4}, // R10 ignored
    {1'b1, 8'hE0, 2'd0, 1'b0, 1'b0, 4'b0110, 8'h01, 1'b1, 3'd0, 3'd0}, // R11 tx clear
    {1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 4'b0111, 8'h01, 1'b1, 3'd1, 3'd0}, // R7 grant page 0
    {1'b1, 8'h40, 2'd0, 1'b0, 1'b0, 4'b0000, 8'h01, 1'b1, 3'd0, 3'd0}, // R6 wipe
    {1'b1, 8'h20, 2'd0, 1'b0, 1'b0, 4'b0001, 8'h00, 1'b1, 3'd0, 3'd0}  // R2 claim after wipe
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tb_free(input logic [N-1:0] m);
    int c = N;
    for (int i = 0; i < N; i++) if (m[i]) c--;
    return c;
  endfunction

  function automatic int tb_lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (!m[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    cmd_we = 1'b0; cmd_byte = 8'h00; rx_req = 1'b0; pkt_num = '0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] prev_map;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "page_map", page_map, 0);
    check("R1", "free_pages", free_pages, N);
    check("R1", "alloc_result", alloc_result, 8'h80);
    check("R1", "alloc_flag", alloc_flag, 0);
    check("R1", "rx_count", rx_count, 0);
    check("R1", "tx_count", tx_count, 0);
    check("R1", "rx_head", rx_head, 8'h80);
    check("R1", "tx_head", tx_head, 8'h80);

    prev_map = '0;
    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      cmd_we = e[31]; cmd_byte = e[30:23]; pkt_num = e[22:21]; rx_req = e[20];
      #1;
      check($sformatf("R7 vec%0d", v), "rx_grant", rx_grant, e[19]);
      if (e[19]) check($sformatf("R7 vec%0d", v), "rx_page", rx_page, tb_lowest(prev_map));
      @(negedge clk);
      idle();
      check($sformatf("vec%0d", v), "page_map", page_map, e[18:15]);
      check($sformatf("vec%0d", v), "alloc_result", alloc_result, e[14:7]);
      check($sformatf("vec%0d", v), "alloc_flag", alloc_flag, e[6]);
      check($sformatf("vec%0d", v), "rx_count", rx_count, e[5:3]);
      check($sformatf("vec%0d", v), "tx_count", tx_count, e[2:0]);
      check($sformatf("R13 vec%0d", v), "free_pages", free_pages, tb_free(e[18:15]));
      prev_map = e[18:15];
    end

    // R2 done pulse lasts one cycle (previous row also claimed, so idle first)
    @(negedge clk);
    check("R2", "alloc_done idle", alloc_done, 0);
    cmd_we = 1'b1; cmd_byte = 8'h20;
    @(negedge clk);
    idle();
    check("R2", "alloc_done pulse", alloc_done, 1);
    check("R2", "alloc_result", alloc_result, 1);
    @(negedge clk);
    check("R2", "alloc_done after", alloc_done, 0);

    // R8 receive queue head
    check("R8", "rx_head empty", rx_head, 8'h80);
    rx_req = 1'b1;
    @(negedge clk);
    idle();
    check("R8", "rx_head", rx_head, 2);
    cmd_we = 1'b1; cmd_byte = 8'h60;
    @(negedge clk);
    idle();
    check("R8", "page kept", page_map, 4'b0111);
    check("R8", "rx_head drained", rx_head, 8'h80);

    // R10 transmit head
    cmd_we = 1'b1; cmd_byte = 8'hC0; pkt_num = 2'd2;
    @(negedge clk);
    cmd_byte = 8'hC0; pkt_num = 2'd1;
    @(negedge clk);
    idle();
    check("R10", "tx_head", tx_head, 2);
    check("R10", "tx_count", tx_count, 2);

    // R11 tx clear keeps map
    cmd_we = 1'b1; cmd_byte = 8'hFF;
    @(negedge clk);
    idle();
    check("R11", "tx_count", tx_count, 0);
    check("R11", "page_map", page_map, 4'b0111);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule